// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects completion events from a bank of transmit DMA channel engines and a bank of receive DMA channel engines, plus one host-error event. It turns them into a single interrupt line for the host. Each event source has one sticky raw status bit. The engine that owns the bit sets it with a one-cycle completion pulse and clears it with a one-cycle acknowledge.

Each direction, and the error group, has an enable mask. Software changes a mask only through a write-one-to-set register and a write-one-to-clear register, so updating one channel never needs a read-modify-write that could race with another channel. The masked status is the raw status ANDed with the mask.

The interrupt line rises when any masked bit is pending. Once it has risen it stays high, even if the pending bits go away, until the host writes zero to the end-of-interrupt register. If masked bits are still pending after that write, the line rises again one cycle later.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset every raw status bit, every mask bit and the `irq` output are zero.
- R2: A one-cycle pulse on `tx_done[n]` or `rx_done[n]` sets bit n of that direction's raw status from the next cycle on. The bit stays set until that same channel's acknowledge arrives.
- R3: A pulse on `tx_ack[n]` or `rx_ack[n]` clears raw bit n. If a completion pulse and an acknowledge for the same bit arrive in the same cycle, the bit ends up set.
- R4: Writing to a group's mask-set register (offset +0x8) enables every bit written as 1 and leaves bits written as 0 unchanged. Reading either the mask-set register or the mask-clear register returns the current mask.
- R5: Writing to a group's mask-clear register (offset +0xC) disables every bit written as 1 and leaves the others unchanged. Writing all ones disables the whole group.
- R6: A group's masked status register (offset +0x4) reads as its raw status ANDed with its mask.
- R7: The error group holds only bit 1, the host-error bit. `host_err` sets it and `host_err_ack` clears it. All other bits of the error group's raw and mask registers read zero and cannot be set.
- R8: When `irq` is low and any masked bit of any group is set, `irq` goes high on the next clock edge. Once high it stays high until an end-of-interrupt write, even if the masked bits are cleared.
- R9: Writing data 0 to the end-of-interrupt register at 0x30 drives `irq` low on the next edge, and this takes priority over pending bits. If bits are still pending, `irq` rises again one edge later. An end-of-interrupt write with nonzero data has no effect.
- R10: The register map is: transmit group at 0x00, receive group at 0x10, error group at 0x20, each with raw at +0x0, masked at +0x4, mask-set at +0x8 and mask-clear at +0xC. The end-of-interrupt register is at 0x30. Address bits [1:0] are ignored. Every other address reads zero and ignores writes, and the raw and masked registers ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | NUM_CH | Transmit completion pulses, one per channel |
| tx_ack | input | NUM_CH | Transmit acknowledge pulses, one per channel |
| rx_done | input | NUM_CH | Receive completion pulses, one per channel |
| rx_ack | input | NUM_CH | Receive acknowledge pulses, one per channel |
| host_err | input | 1 | Host-error event pulse |
| host_err_ack | input | 1 | Host-error acknowledge pulse |
| reg_addr | input | ADDR_W | Byte address of the register port |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt line to the host |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a completion pulse and an acknowledge on the same channel. The bench drives directed collisions on one transmit bit, and its random phase also lets them collide freely. The reference model gives set priority, so the bench expects the bit to read back as set.

The second pair is an end-of-interrupt write and bits that are still pending. The bench expects `irq` to drop for exactly one cycle and then return. During the random phase, end-of-interrupt writes land on arbitrary pending states, and the model judges every resulting `irq` edge.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
   // group selector, taken from address bits [5:4]
   localparam logic [1:0] GRP_TX  = 2'd0;
   localparam logic [1:0] GRP_RX  = 2'd1;
   localparam logic [1:0] GRP_ERR = 2'd2;
   localparam logic [1:0] GRP_CTL = 2'd3;

   // register within a group, taken from address bits [3:2]
   typedef enum logic [1:0] {
      SUB_RAW    = 2'd0,
      SUB_MASKED = 2'd1,
      SUB_SET    = 2'd2,
      SUB_CLR    = 2'd3
   } sub_e;

   // position of the host-error bit in the error group
   localparam int HOST_ERR_BIT = 1;
   localparam int REG_W        = 32;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
   parameter int            NUM_CH = 8,
   parameter logic [31:0]   IMPL   = 32'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic [NUM_CH-1:0] clr_i,
   input  logic              w1s_i,
   input  logic              w1c_i,
   input  logic [NUM_CH-1:0] wbits_i,
   output logic [NUM_CH-1:0] raw_o,
   output logic [NUM_CH-1:0] mask_o,
   output logic [NUM_CH-1:0] masked_o
);
   localparam logic [NUM_CH-1:0] IMPL_V = IMPL[NUM_CH-1:0];

   for (genvar b = 0; b < NUM_CH; b++) begin : g_bit
      if (IMPL[b]) begin : g_live
         logic raw_q, mask_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               raw_q  <= 1'b0;
               mask_q <= 1'b0;
            end else begin
               // a new completion wins over a simultaneous acknowledge
               if (set_i[b])      raw_q <= 1'b1;
               else if (clr_i[b]) raw_q <= 1'b0;
               if (w1s_i && wbits_i[b])      mask_q <= 1'b1;
               else if (w1c_i && wbits_i[b]) mask_q <= 1'b0;
            end
         end
         assign raw_o[b]  = raw_q;
         assign mask_o[b] = mask_q;
      end else begin : g_tie
         assign raw_o[b]  = 1'b0;
         assign mask_o[b] = 1'b0;
      end
   end

   assign masked_o = raw_o & mask_o;

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      |(set_i & IMPL_V) |=> ((raw_o & $past(set_i & IMPL_V)) == $past(set_i & IMPL_V))); // R2
   AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      |(raw_o & ~clr_i) |=> ((raw_o & $past(raw_o & ~clr_i)) == $past(raw_o & ~clr_i))); // R3
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      |(clr_i & ~set_i) |=> ((raw_o & $past(clr_i & ~set_i)) == '0)); // R3
   AST_W1S: assert property (@(posedge clk) disable iff (!rst_n)
      w1s_i |=> ((mask_o & $past(wbits_i & IMPL_V)) == $past(wbits_i & IMPL_V))); // R4
   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      w1c_i |=> ((mask_o & $past(wbits_i)) == '0)); // R5
   AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(w1s_i || w1c_i) |=> $stable(mask_o)); // R4
endmodule

// File: rtl/irq_line.sv
module irq_line (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_i,
   input  logic eoi_i,
   output logic irq_o
);
   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      irq_q <= 1'b0;
      else if (eoi_i)  irq_q <= 1'b0;
      else if (pend_i) irq_q <= 1'b1;
   end

   assign irq_o = irq_q;

   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_i && !eoi_i) |=> irq_o); // R8
   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !eoi_i) |=> irq_o); // R8
   AST_EOI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_i |=> !irq_o); // R9
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && !pend_i) |=> !irq_o); // R8
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
   import dmairq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tx_done,
   input  logic [NUM_CH-1:0] tx_ack,
   input  logic [NUM_CH-1:0] rx_done,
   input  logic [NUM_CH-1:0] rx_ack,
   input  logic              host_err,
   input  logic              host_err_ack,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq
);
   localparam int SUB_LSB = 2;
   localparam int GRP_LSB = 4;
   localparam int MAP_W   = 6;
   localparam logic [31:0] ALL_IMPL = (NUM_CH >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NUM_CH) - 32'd1);
   localparam logic [31:0] ERR_IMPL = 32'd1 << HOST_ERR_BIT;

   if (NUM_CH < 2 || NUM_CH > REG_W) begin : g_bad_ch
      $error("NUM_CH must lie between 2 and 32");
   end
   if (ADDR_W < MAP_W) begin : g_bad_aw
      $error("ADDR_W must cover the 64-byte window");
   end

   // ---------------- address decode ----------------
   logic       in_win;
   logic [1:0] grp;
   sub_e       sub;

   if (ADDR_W > MAP_W) begin : g_hi
      assign in_win = (reg_addr[ADDR_W-1:MAP_W] == '0);
   end else begin : g_nohi
      assign in_win = 1'b1;
   end
   assign grp = reg_addr[GRP_LSB +: 2];
   assign sub = sub_e'(reg_addr[SUB_LSB +: 2]);

   logic eoi;
   assign eoi = reg_wr && in_win && (grp == GRP_CTL) && (sub == SUB_RAW) && (reg_wdata == '0);

   // ---------------- status groups ----------------
   logic [NUM_CH-1:0] set_v  [3];
   logic [NUM_CH-1:0] clr_v  [3];
   logic [NUM_CH-1:0] raw_v  [3];
   logic [NUM_CH-1:0] mask_v [3];
   logic [NUM_CH-1:0] mskd_v [3];

   assign set_v[0] = tx_done;
   assign clr_v[0] = tx_ack;
   assign set_v[1] = rx_done;
   assign clr_v[1] = rx_ack;
   assign set_v[2] = NUM_CH'(host_err)     << HOST_ERR_BIT;
   assign clr_v[2] = NUM_CH'(host_err_ack) << HOST_ERR_BIT;

   for (genvar g = 0; g < 3; g++) begin : g_grp
      logic hit;
      assign hit = reg_wr && in_win && (grp == 2'(g));
      irq_group #(
         .NUM_CH (NUM_CH),
         .IMPL   ((g == 2) ? ERR_IMPL : ALL_IMPL)
      ) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (set_v[g]),
         .clr_i    (clr_v[g]),
         .w1s_i    (hit && (sub == SUB_SET)),
         .w1c_i    (hit && (sub == SUB_CLR)),
         .wbits_i  (reg_wdata[NUM_CH-1:0]),
         .raw_o    (raw_v[g]),
         .mask_o   (mask_v[g]),
         .masked_o (mskd_v[g])
      );
   end

   logic pend;
   assign pend = |{mskd_v[0], mskd_v[1], mskd_v[2]};

   irq_line u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .eoi_i  (eoi),
      .irq_o  (irq)
   );

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if (in_win && grp != GRP_CTL) begin
         unique case (sub)
            SUB_RAW:    reg_rdata = 32'(raw_v[grp]);
            SUB_MASKED: reg_rdata = 32'(mskd_v[grp]);
            SUB_SET,
            SUB_CLR:    reg_rdata = 32'(mask_v[grp]);
            default:    reg_rdata = '0;
         endcase
      end
   end

   AST_ERR_ONLY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && grp == GRP_ERR) |-> ((reg_rdata & ~ERR_IMPL) == '0)); // R7
   AST_CTL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_win || grp == GRP_CTL) |-> (reg_rdata == '0)); // R10
endmodule

// File: tb/sim_dma_irq_aggregator.sv
`timescale 1ns/1ps
module sim_dma_irq_aggregator;
   localparam int NCH = 8;
   localparam int AW  = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] tx_done = '0, tx_ack = '0, rx_done = '0, rx_ack = '0;
   logic           host_err = 1'b0, host_err_ack = 1'b0;
   logic [AW-1:0]  reg_addr = '0;
   logic           reg_wr = 1'b0;
   logic [31:0]    reg_wdata = '0;
   logic [31:0]    reg_rdata;
   logic           irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   dma_irq_aggregator #(.NUM_CH(NCH), .ADDR_W(AW)) u0 (
      .clk, .rst_n, .tx_done, .tx_ack, .rx_done, .rx_ack,
      .host_err, .host_err_ack, .reg_addr, .reg_wr, .reg_wdata,
      .reg_rdata, .irq
   );

   // ---------------- behavioural reference model ----------------
   bit [7:0] m_raw  [3];
   bit [7:0] m_mask [3];
   bit       m_irq;

   function automatic bit [7:0] impl_of(int g);
      return (g == 2) ? 8'h02 : 8'hFF;
   endfunction

   function automatic bit [31:0] model_read(bit [7:0] a);
      int g = a[5:4];
      int s = a[3:2];
      if (a[7:6] != 0 || g == 3) return 0;
      case (s)
         0: return {24'b0, m_raw[g]};
         1: return {24'b0, m_raw[g] & m_mask[g]};
         default: return {24'b0, m_mask[g]};
      endcase
   endfunction

   function automatic string tag_of(bit [7:0] a);
      if (a[7:6] != 0 || a[5:4] == 3) return "R10";
      if (a[5:4] == 2) return "R7";
      case (a[3:2])
         0: return "R2";
         1: return "R6";
         default: return "R4";
      endcase
   endfunction

   always @(posedge clk) begin
      bit [7:0] nraw [3];
      bit [7:0] nmask [3];
      bit [7:0] setv [3];
      bit [7:0] clrv [3];
      bit       pend;
      bit       eoi;
      if (!rst_n) begin
         for (int g = 0; g < 3; g++) begin m_raw[g] = 0; m_mask[g] = 0; end
         m_irq = 0;
      end else begin
         setv[0] = tx_done; clrv[0] = tx_ack;
         setv[1] = rx_done; clrv[1] = rx_ack;
         setv[2] = {6'b0, host_err, 1'b0}; clrv[2] = {6'b0, host_err_ack, 1'b0};
         pend = 0;
         for (int g = 0; g < 3; g++) begin
            pend |= |(m_raw[g] & m_mask[g]);
            nraw[g] = ((m_raw[g] & ~clrv[g]) | setv[g]) & impl_of(g);
            nmask[g] = m_mask[g];
            if (reg_wr && reg_addr[7:6] == 0 && reg_addr[5:4] == g) begin
               if (reg_addr[3:2] == 2) nmask[g] = m_mask[g] | (reg_wdata[7:0] & impl_of(g));
               if (reg_addr[3:2] == 3) nmask[g] = m_mask[g] & ~reg_wdata[7:0];
            end
         end
         eoi = reg_wr && reg_addr[7:6] == 0 && reg_addr[5:2] == 4'hC && reg_wdata == 0;
         for (int g = 0; g < 3; g++) begin m_raw[g] = nraw[g]; m_mask[g] = nmask[g]; end
         m_irq = eoi ? 1'b0 : (m_irq | pend);
      end
      #1;
      // per-clock comparison against the model
      n_vec++;
      if (irq !== m_irq) begin
         n_bad++;
         $display("FAIL R8 irq at %0t: got %0b exp %0b", $time, irq, m_irq);
      end
      n_vec++;
      if (reg_rdata !== model_read(reg_addr)) begin
         n_bad++;
         $display("FAIL %s read @%02h at %0t: got %08h exp %08h",
                  tag_of(reg_addr), reg_addr, $time, reg_rdata, model_read(reg_addr));
      end
   end

   // ---------------- directed helpers ----------------
   task automatic chk(string tag, bit [31:0] got, bit [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h exp %08h", tag, got, exp);
      end
   endtask

   task automatic rd(bit [7:0] a, string tag, bit [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #0.5;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic wr(bit [7:0] a, bit [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_irq(string tag, bit exp);
      #0.5;
      chk(tag, {31'b0, irq}, {31'b0, exp});
   endtask

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      rd(8'h00, "R1", 0); rd(8'h08, "R1", 0); rd(8'h18, "R1", 0); rd(8'h28, "R1", 0);
      chk_irq("R1", 0);

      // R2: completion sets the channel's own bit
      @(negedge clk); tx_done = 8'h08; @(negedge clk); tx_done = 0;
      rd(8'h00, "R2", 32'h08);
      rd(8'h04, "R6", 0);
      chk_irq("R8", 0);
      // R4: set-mask, zeros leave bits alone
      wr(8'h08, 32'h0C);
      wr(8'h08, 32'h00);
      rd(8'h08, "R4", 32'h0C); rd(8'h0C, "R4", 32'h0C);
      rd(8'h04, "R6", 32'h08);
      chk_irq("R8", 1);
      // writes to the raw register are ignored (R10)
      wr(8'h00, 32'hFF);
      rd(8'h00, "R10", 32'h08);

      // receive channel 7
      @(negedge clk); rx_done = 8'h80; @(negedge clk); rx_done = 0;
      wr(8'h18, 32'h80);
      rd(8'h14, "R6", 32'h80);
      // R9: nonzero data does nothing
      wr(8'h30, 32'h1);
      chk_irq("R9", 1);
      // R9: EOI drops for one cycle, then rises again
      @(negedge clk); reg_addr = 8'h30; reg_wdata = 0; reg_wr = 1;
      @(negedge clk); reg_wr = 0;
      chk_irq("R9", 0);
      @(negedge clk);
      chk_irq("R9", 1);

      // R3: acknowledges clear
      @(negedge clk); tx_ack = 8'h08; rx_ack = 8'h80;
      @(negedge clk); tx_ack = 0; rx_ack = 0;
      rd(8'h00, "R3", 0); rd(8'h10, "R3", 0);
      chk_irq("R8", 1);                 // held with nothing pending
      wr(8'h30, 0);
      idle(1);
      chk_irq("R9", 0);

      // R3: completion and acknowledge collide on channel 5
      @(negedge clk); tx_done = 8'h20; tx_ack = 8'h20;
      @(negedge clk); tx_done = 0; tx_ack = 0;
      rd(8'h00, "R3", 32'h20);

      // R5: clear-all
      wr(8'h0C, 32'hFFFF_FFFF);
      rd(8'h08, "R5", 0);
      wr(8'h18, 32'hA5); wr(8'h1C, 32'h05);
      rd(8'h1C, "R5", 32'hA0);

      // R7: host error bit
      @(negedge clk); host_err = 1; @(negedge clk); host_err = 0;
      rd(8'h20, "R7", 32'h02);
      wr(8'h28, 32'hFF);
      rd(8'h28, "R7", 32'h02);
      rd(8'h24, "R7", 32'h02);
      @(negedge clk); host_err_ack = 1; @(negedge clk); host_err_ack = 0;
      rd(8'h20, "R7", 0);

      // R10: unmapped addresses, ignored low address bits
      rd(8'h34, "R10", 0); rd(8'h40, "R10", 0); rd(8'h1B, "R10", 32'hA0);
      wr(8'h30, 0);

      // random phase: model compares every clock
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         tx_done = 8'($urandom) & 8'($urandom);
         tx_ack  = 8'($urandom) & 8'($urandom);
         rx_done = 8'($urandom) & 8'($urandom);
         rx_ack  = 8'($urandom) & 8'($urandom);
         host_err = ($urandom % 8) == 0;
         host_err_ack = ($urandom % 8) == 0;
         reg_addr = 8'($urandom % 64);
         if (($urandom % 16) == 0) reg_addr = 8'($urandom);
         reg_wr = ($urandom % 3) == 0;
         reg_wdata = $urandom;
         if (($urandom % 4) == 0) begin reg_addr = 8'h30; reg_wdata = 0; end
      end
      @(negedge clk);
      tx_done = 0; tx_ack = 0; rx_done = 0; rx_ack = 0;
      host_err = 0; host_err_ack = 0; reg_wr = 0;
      idle(3);
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule